// File: doc/BRIEF.md
# Chainable Decimal Digit Counter

This block counts in decimal, one digit per stage, with every bit updated on the rising clock edge. Each stage holds a four-bit binary-coded decimal value that runs 0 to 9 and wraps to 0. A stage can be preset from a data bus, cleared at once by an active-low clear, and advanced only when both of its enables are high. One enable is shared by all stages. The other is a carry-in that also gates the stage's terminal-count flag.

The top module chains a parameter-set number of identical stages into a multi-digit counter. Clock, clear and load are common to all stages. The shared count enable goes to every stage. Each stage's terminal-count flag drives the carry-in of the stage above, and the flag of the top stage leaves the block as the carry output. Digit 0 is the least significant digit.

Top module: `decade_chain`

## Requirements
- R1: While `clr_n` is low, every digit of `count` is 0 at once, without waiting for a clock edge and whatever the levels on `load_n`, `cnt_en` and `carry_in`.
- R2: When `load_n` is low at a rising edge, `count` takes `load_val` on that edge, whether the enables are high or low.
- R3: With `load_n` high, the counter changes only when both `cnt_en` and `carry_in` are high. Otherwise `count` holds.
- R4: When digit 0 counts, it steps 0,1,...,9 and goes from 9 back to 0.
- R5: `carry_out` is high exactly when `carry_in` is high and every digit reads 9. This holds whatever the level on `cnt_en`.
- R6: A digit holding a code from 10 to 15 goes to 0 on its next count step. A stage with such a code never asserts its terminal count, so the digits above it hold.
- R7: A digit above digit 0 advances only on an edge where every digit below it reads 9 and the counter counts. The chain therefore counts its decimal value modulo 10 to the power of the digit count.
- R8: Digit i of `count` and of `load_val` sits in bits [4i+3:4i].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable shared by all stages |
| carry_in | input | 1 | Carry-in enable of digit 0; it also gates the terminal count |
| load_val | input | 4*N_DIGITS | Preset value, one BCD digit per nibble |
| count | output | 4*N_DIGITS | Current counter value, one BCD digit per nibble |
| carry_out | output | 1 | Terminal count of the top digit |

## Verification
The hardest state to reach from the ports is a counter whose upper digit holds a code from 10 to 15 while a lower digit sits at 9. Only a parallel load can create it, and it must then be followed by a single count step so the effect on the digit above shows. The stimulus loads such mixed values and counts once. It also presets values just below rollover and counts across the 999-to-000 wrap against a decimal model. Clear is pulled low between clock edges while a load is pending, to show that clear wins without any edge.

// File: rtl/decade_pkg.sv
`timescale 1ns/1ps
package decade_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_LAST = 4'd9;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/decade_next.sv
`timescale 1ns/1ps
// Next-state and update-enable logic for one decimal digit
module decade_next
  import decade_pkg::*;
(
  input  digit_t cur,
  input  digit_t preset,
  input  logic   load_n,
  input  logic   en_par,
  input  logic   en_carry,
  output digit_t nxt,
  output logic   upd
);
  logic step;

  always_comb begin
    step = en_par && en_carry;
    upd  = !load_n || step;
    if (!load_n) begin
      nxt = preset;
    end else if (cur >= DIGIT_LAST) begin
      // 9 wraps; illegal codes 10..15 recover to 0
      nxt = '0;
    end else begin
      nxt = cur + digit_t'(1);
    end
  end
endmodule

// File: rtl/decade_stage.sv
`timescale 1ns/1ps
// One BCD digit: register, next-state logic and terminal count
module decade_stage
  import decade_pkg::*;
(
  input  logic   clk,
  input  logic   clr_n,
  input  logic   load_n,
  input  logic   en_par,
  input  logic   en_carry,
  input  digit_t preset,
  output digit_t q,
  output logic   tc
);
  digit_t q_r;
  digit_t q_nxt;
  logic   q_upd;

  decade_next u_next (
    .cur      (q_r),
    .preset   (preset),
    .load_n   (load_n),
    .en_par   (en_par),
    .en_carry (en_carry),
    .nxt      (q_nxt),
    .upd      (q_upd)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      q_r <= '0;
    end else if (q_upd) begin
      q_r <= q_nxt;
    end
  end

  // Terminal count: carry enable fed forward, independent of en_par
  always_comb begin
    tc = en_carry && (q_r == DIGIT_LAST);
  end

  assign q = q_r;
endmodule

// File: rtl/decade_chain.sv
`timescale 1ns/1ps
// N-digit decimal counter built from cascaded BCD stages
module decade_chain
  import decade_pkg::*;
#(
  parameter int N_DIGITS = 3
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic                        cnt_en,
  input  logic                        carry_in,
  input  logic [N_DIGITS*DIGIT_W-1:0] load_val,
  output logic [N_DIGITS*DIGIT_W-1:0] count,
  output logic                        carry_out
);
  localparam int BUS_W = N_DIGITS * DIGIT_W;

  logic [N_DIGITS:0] carry_link;

  assign carry_link[0] = carry_in;

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
    digit_t q_g;

    decade_stage u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .load_n   (load_n),
      .en_par   (cnt_en),
      .en_carry (carry_link[g]),
      .preset   (load_val[g*DIGIT_W +: DIGIT_W]),
      .q        (q_g),
      .tc       (carry_link[g+1])
    );

    assign count[g*DIGIT_W +: DIGIT_W] = q_g;
  end

  assign carry_out = carry_link[N_DIGITS];

  initial begin
    if (BUS_W != N_DIGITS * 4) $display("decade_chain: unexpected digit width");
  end
endmodule

// File: rtl/decade_chain_chk.sv
`timescale 1ns/1ps
module decade_chain_chk
  import decade_pkg::*;
#(
  parameter int N_DIGITS = 3
) (
  input logic                        clk,
  input logic                        clr_n,
  input logic                        load_n,
  input logic                        cnt_en,
  input logic                        carry_in,
  input logic [N_DIGITS*DIGIT_W-1:0] load_val,
  input logic [N_DIGITS*DIGIT_W-1:0] count,
  input logic                        carry_out
);
  localparam int BUS_W = N_DIGITS * DIGIT_W;

  logic all_nine;
  logic stepping;

  always_comb begin
    all_nine = 1'b1;
    for (int i = 0; i < N_DIGITS; i++) begin
      if (count[i*DIGIT_W +: DIGIT_W] != DIGIT_LAST) all_nine = 1'b0;
    end
    stepping = load_n && cnt_en && carry_in;
  end

  always @(negedge clk) begin
    if (!clr_n) begin
      assert_clear_zero_R1: assert (count == '0);
    end
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(load_val));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(cnt_en && carry_in)) |=> $stable(count));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (stepping && count[DIGIT_W-1:0] == DIGIT_LAST) |=> count[DIGIT_W-1:0] == '0);

  assert_carry_out_R5: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == (carry_in && all_nine));

  assert_bad_code_R6: assert property (@(posedge clk) disable iff (!clr_n)
    (stepping && count[DIGIT_W-1:0] > DIGIT_LAST) |=> count[DIGIT_W-1:0] == '0);

  if (N_DIGITS > 1) begin : g_upper
    assert_upper_hold_R7: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && count[DIGIT_W-1:0] != DIGIT_LAST)
      |=> count[BUS_W-1:DIGIT_W] == $past(count[BUS_W-1:DIGIT_W]));
  end
endmodule

bind decade_chain decade_chain_chk #(.N_DIGITS(N_DIGITS)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .cnt_en    (cnt_en),
  .carry_in  (carry_in),
  .load_val  (load_val),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/decade_chain_tb.sv
`timescale 1ns/1ps
module decade_chain_tb;
  localparam int ND = 3;
  localparam int BW = ND * 4;

  logic          clk;
  logic          clr_n;
  logic          load_n;
  logic          cnt_en;
  logic          carry_in;
  logic [BW-1:0] load_val;
  logic [BW-1:0] count;
  logic          carry_out;

  int checks = 0;
  int errors = 0;

  decade_chain #(.N_DIGITS(ND)) u_dut (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .carry_in  (carry_in),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {load_n, cnt_en, carry_in, load_val, expected count, expected carry_out}
  localparam int NV = 16;
  localparam logic [27:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 12'h998, 12'h998, 1'b0},  // R2 R8 load with enables low
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h999, 1'b1},  // R4 R5
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0},  // R7 full wrap
    {1'b1, 1'b0, 1'b1, 12'h000, 12'h000, 1'b0},  // R3 cnt_en low holds
    {1'b0, 1'b0, 1'b0, 12'h0C9, 12'h0C9, 1'b0},  // R2 R6 load bad middle digit
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h000, 1'b0},  // R6 bad digit recovers to 0
    {1'b0, 1'b1, 1'b1, 12'h5A7, 12'h5A7, 1'b0},  // R2 load beats enables
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h5A8, 1'b0},  // R4
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h5A9, 1'b0},  // R4
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h500, 1'b0},  // R6 R7 bad code: top digit holds
    {1'b1, 1'b1, 1'b0, 12'h000, 12'h500, 1'b0},  // R3 carry_in low holds
    {1'b0, 1'b1, 1'b1, 12'h989, 12'h989, 1'b0},  // R2 R8
    {1'b1, 1'b1, 1'b1, 12'h000, 12'h990, 1'b0},  // R7 middle digit carries
    {1'b0, 1'b0, 1'b1, 12'h999, 12'h999, 1'b1},  // R5 carry_out without cnt_en
    {1'b1, 1'b0, 1'b1, 12'h000, 12'h999, 1'b1},  // R3 R5 hold, flag stays
    {1'b1, 1'b0, 1'b0, 12'h000, 12'h999, 1'b0}   // R5 carry_in gates flag
  };

  task automatic check(input string tag, input logic [BW-1:0] got,
                       input logic [BW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [BW-1:0] to_bcd(input int v);
    logic [BW-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < ND; i++) begin
      r[i*4 +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int model;
    clr_n    = 1'b0;
    load_n   = 1'b1;
    cnt_en   = 1'b0;
    carry_in = 1'b0;
    load_val = '0;
    #12;
    check("R1 reset count", count, '0);
    check("R1 reset carry_out", BW'(carry_out), '0);

    @(negedge clk);
    clr_n = 1'b1;

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      load_n   = VEC[v][27];
      cnt_en   = VEC[v][26];
      carry_in = VEC[v][25];
      load_val = VEC[v][24:13];
      @(posedge clk);
      #2;
      check($sformatf("R2-R8 vec %0d count", v), count, VEC[v][12:1]);
      check($sformatf("R5 vec %0d carry_out", v), BW'(carry_out), BW'(VEC[v][0]));
    end

    // R7 R4 multi-digit rollover against a decimal model
    @(negedge clk);
    load_n = 1'b0; load_val = 12'h993; cnt_en = 1'b1; carry_in = 1'b1;
    @(posedge clk);
    #2;
    model = 993;
    check("R2 preset 993", count, to_bcd(model));
    @(negedge clk);
    load_n = 1'b1;
    for (int k = 0; k < 14; k++) begin
      @(posedge clk);
      #2;
      model = (model + 1) % 1000;
      check("R7 rollover count", count, to_bcd(model));
      check("R5 rollover carry_out", BW'(carry_out), BW'(model == 999));
    end

    // R6 all digits illegal
    @(negedge clk);
    load_n = 1'b0; load_val = 12'hFFF; cnt_en = 1'b0; carry_in = 1'b1;
    @(posedge clk);
    #2;
    check("R6 load FFF", count, 12'hFFF);
    check("R6 no carry_out on FFF", BW'(carry_out), '0);
    @(negedge clk);
    load_n = 1'b1; cnt_en = 1'b1;
    @(posedge clk);
    #2;
    check("R6 FFF steps to FF0", count, 12'hFF0);

    // R1 clear in mid-cycle, overriding a pending load
    @(negedge clk);
    load_n = 1'b0; load_val = 12'h123;
    @(posedge clk);
    #2;
    check("R2 preset 123", count, 12'h123);
    #1;
    clr_n = 1'b0;
    #1;
    check("R1 clear without edge", count, '0);
    @(negedge clk);
    load_n = 1'b0; load_val = 12'h777; cnt_en = 1'b1; carry_in = 1'b1;
    @(posedge clk);
    #2;
    check("R1 clear beats load", count, '0);
    @(negedge clk);
    clr_n = 1'b1; load_n = 1'b1;
    @(posedge clk);
    #2;
    check("R3 count after clear release", count, 12'h001);

    finish_run();
  end
endmodule